// File: doc/BRIEF.md
# High-Speed Transmit Serializer

This block is the transmit half of a USB 2.0 transceiver macrocell. It works in the parallel clock domain and moves one line bit per clock. The link layer talks to it through a byte handshake. The link layer raises `tx_valid` with the first byte (the PID) already on `tx_data`. It then advances to the next byte on every rising edge where `tx_valid` and `tx_ready` are both high. It ends the packet by dropping `tx_valid`. The block never creates a PID or a CRC. Every byte it sends comes from the link layer.

Each accepted byte waits in a one-byte holding register until the shifter is free. The shifter sends it least significant bit first. The block first waits a short start delay. It then sends a SYNC field, the data with zero bits inserted after runs of ones, and an end-of-packet field. The line stream is NRZI encoded and appears on `ser_bit`, qualified by the strobe `ser_en`.

`op_mode` sets the line behaviour:
- mode 0 (and mode 3): normal operation.
- mode 1: the block stays silent.
- mode 2: the raw bits are sent with no stuffing and no NRZI encoding.

Top module: `hs_tx_serializer`

## Requirements
- R1: After reset, `tx_ready` and `ser_en` are low and `ser_bit` is 1, the idle line level.
- R2: A byte is taken only on a rising edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low on the cycle after a byte is taken. Bytes go out in the order they were taken, each least significant bit first.
- R3: A packet starts when `tx_valid` is sampled high while the block is idle. The first `ser_en` strobe follows 8 to 16 clocks after that edge. The SYNC field is 31 raw zero bits and then a raw one.
- R4: In mode 0, a raw zero is inserted after six raw ones in a row. The SYNC's final one counts as the first one of a run. A zero that the rule calls for after the last data bit is still sent.
- R5: NRZI: a raw 0 toggles `ser_bit` and a raw 1 holds it. The line starts each packet at 1.
- R6: After `tx_valid` falls and all taken bytes have been sent, eight end-of-packet bits follow. These are unstuffed raw ones, so the line holds its level. `ser_en` then goes low.
- R7: Once `tx_valid` has been sampled low during a packet, `tx_ready` stays low until that packet is over.
- R8: Mode 2 (`op_mode`=2'b10), sampled at packet start, sends the raw bits on `ser_bit` with no stuff bits and no NRZI.
- R9: Mode 1 (`op_mode`=2'b01) ignores `tx_valid`. `tx_ready` and `ser_en` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Link layer has a packet byte on `tx_data` |
| tx_data | input | 8 | Packet byte, the PID first |
| op_mode | input | 2 | 0 normal, 1 silent, 2 raw, 3 treated as normal |
| tx_ready | output | 1 | Holding register can take a byte this cycle |
| ser_bit | output | 1 | Encoded line bit |
| ser_en | output | 1 | `ser_bit` carries a line bit this cycle |

## Verification
Some properties are checked on every cycle:
- the holding register blocks `tx_ready` right after a byte is taken;
- `tx_ready` stays low once `tx_valid` has dropped;
- the run-of-ones counter never goes past six;
- the first strobe of a packet lands inside the start window;
- silent mode keeps the block idle.

The exact bit stream can only be shown by the bench's packets. It compares the strobed `ser_bit` sequence with a model of SYNC, stuffing, NRZI and end-of-packet. The packets include runs of 0xFF, a final byte that forces a trailing stuff bit, all-zero data and a raw-mode packet.

// File: rtl/hs_tx_pkg.sv
package hs_tx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_SYNC,
        S_DATA,
        S_EOP
    } tx_state_e;

    localparam logic [1:0] MODE_SILENT = 2'b01;
    localparam logic [1:0] MODE_RAW    = 2'b10;
endpackage

// File: rtl/hs_tx_line_coder.sv
// One NRZI step: a raw 0 toggles the line, a raw 1 holds it (R5).
// When encoding is off, the raw bit goes straight to the line (R8).
module hs_tx_line_coder (
    input  logic raw_bit,
    input  logic nrzi_en,
    input  logic line_q,
    output logic line_d
);
    always_comb begin
        if (nrzi_en) line_d = raw_bit ? line_q : ~line_q;
        else         line_d = raw_bit;
    end
endmodule

// File: rtl/hs_tx_serializer.sv
module hs_tx_serializer #(
    parameter int DATA_W     = 8,
    parameter int SYNC_LEN   = 32,
    parameter int SYNC_DELAY = 8,
    parameter int EOP_LEN    = 8,
    parameter int STUFF_RUN  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [1:0]        op_mode,
    output logic              tx_ready,
    output logic              ser_bit,
    output logic              ser_en
);
    import hs_tx_pkg::*;

    localparam int CNT_MAX = (SYNC_LEN > SYNC_DELAY) ?
                             ((SYNC_LEN > EOP_LEN) ? SYNC_LEN : EOP_LEN) :
                             ((SYNC_DELAY > EOP_LEN) ? SYNC_DELAY : EOP_LEN);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam int SH_W  = $clog2(DATA_W + 1);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] hold;
        logic              hold_full;
        logic [DATA_W-1:0] sh;
        logic [SH_W-1:0]   sh_cnt;
        logic [RUN_W-1:0]  ones;
        logic              ended;
        logic              raw_mode;
        logic              line;
        logic              ser_en;
    } regs_t;

    regs_t q, d;

    // bit source decisions for the current cycle
    logic emit, raw_bit, is_eop, take_sh, line_next, in_pkt;

    assign in_pkt = (q.st == S_SYNC) || (q.st == S_DATA);

    always_comb begin
        emit    = 1'b0;
        raw_bit = 1'b1;
        is_eop  = 1'b0;
        take_sh = 1'b0;
        unique case (q.st)
            S_SYNC: begin
                emit    = 1'b1;
                raw_bit = (q.cnt == CNT_W'(SYNC_LEN - 1));  // R3
            end
            S_DATA: begin
                if (!q.raw_mode && q.ones == RUN_W'(STUFF_RUN)) begin
                    emit    = 1'b1;                          // R4 stuff bit
                    raw_bit = 1'b0;
                end else if (q.sh_cnt != '0) begin
                    emit    = 1'b1;
                    raw_bit = q.sh[0];                       // R2 LSB first
                    take_sh = 1'b1;
                end
            end
            S_EOP: begin
                emit   = 1'b1;
                is_eop = 1'b1;                               // R6 unstuffed ones
            end
            default: ;
        endcase
    end

    hs_tx_line_coder i_coder (
        .raw_bit (raw_bit),
        .nrzi_en (!q.raw_mode),
        .line_q  (q.line),
        .line_d  (line_next)
    );

    assign tx_ready = in_pkt && !q.hold_full && !q.ended;    // R2, R7
    assign ser_bit  = q.line;
    assign ser_en   = q.ser_en;

    always_comb begin
        d        = q;
        d.ser_en = emit;

        if (tx_valid && tx_ready) begin
            d.hold      = tx_data;
            d.hold_full = 1'b1;
        end
        if (take_sh) begin
            d.sh     = q.sh >> 1;
            d.sh_cnt = q.sh_cnt - 1'b1;
        end
        if (emit) begin
            d.line = line_next;
            if (raw_bit && !is_eop && !q.raw_mode) d.ones = q.ones + 1'b1;
            else                                   d.ones = '0;
        end
        if (in_pkt && !tx_valid) d.ended = 1'b1;             // R7

        unique case (q.st)
            S_IDLE: begin
                d.line  = 1'b1;                              // R1, R5
                d.ones  = '0;
                d.ended = 1'b0;
                d.cnt   = '0;
                if (tx_valid && op_mode != MODE_SILENT) begin // R9
                    d.st       = S_PREP;
                    d.raw_mode = (op_mode == MODE_RAW);      // R8
                end
            end
            S_PREP: begin
                if (q.cnt == CNT_W'(SYNC_DELAY - 1)) begin
                    d.st  = S_SYNC;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_SYNC: begin
                if (q.cnt == CNT_W'(SYNC_LEN - 1)) begin
                    d.st  = S_DATA;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_DATA: begin
                if (!emit && q.ended && !q.hold_full) begin
                    d.st  = S_EOP;
                    d.cnt = '0;
                end
            end
            S_EOP: begin
                if (q.cnt == CNT_W'(EOP_LEN - 1)) d.st = S_IDLE;
                else                              d.cnt = q.cnt + 1'b1;
            end
            default: d.st = S_IDLE;
        endcase

        // refill the shifter from the holding register without a gap
        if (in_pkt && d.sh_cnt == '0 && q.hold_full) begin
            d.sh        = q.hold;
            d.sh_cnt    = SH_W'(DATA_W);
            d.hold_full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    tx_state_e        st_q;
    logic [RUN_W-1:0] ones_q;
    assign st_q   = q.st;
    assign ones_q = q.ones;
endmodule

// File: rtl/hs_tx_checker.sv
module hs_tx_checker #(
    parameter int STUFF_RUN = 6,
    parameter int RUN_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_valid,
    input logic                 tx_ready,
    input logic [1:0]           op_mode,
    input logic                 ser_en,
    input hs_tx_pkg::tx_state_e st,
    input logic [RUN_W-1:0]     ones
);
    import hs_tx_pkg::*;

    localparam int LAT_MIN = 8;
    localparam int LAT_MAX = 16;

    logic [4:0] lat;
    logic       seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat  <= '0;
            seen <= 1'b0;
        end else if (st == S_IDLE) begin
            lat  <= '0;
            seen <= 1'b0;
        end else begin
            if (lat != 5'd31) lat <= lat + 1'b1;
            seen <= seen | ser_en;
        end
    end

    a_r2_take_fills: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready);

    a_r7_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SYNC || st == S_DATA) && !tx_valid |=> !tx_ready);

    a_r4_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RUN_W'(STUFF_RUN));

    a_r3_start_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_en) && !seen |-> (lat >= LAT_MIN && lat <= LAT_MAX));

    a_r9_silent_idle: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_IDLE && op_mode == MODE_SILENT |=> st == S_IDLE);
endmodule

bind hs_tx_serializer hs_tx_checker #(
    .STUFF_RUN (STUFF_RUN),
    .RUN_W     (RUN_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .op_mode  (op_mode),
    .ser_en   (ser_en),
    .st       (st_q),
    .ones     (ones_q)
);

// File: tb/test_hs_tx_serializer.sv
module test_hs_tx_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [1:0] op_mode = 2'b00;
    logic       tx_ready, ser_bit, ser_en;

    always #4 clk = ~clk;

    hs_tx_serializer i_hs_tx_serializer (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .op_mode(op_mode), .tx_ready(tx_ready), .ser_bit(ser_bit), .ser_en(ser_en)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] pkt [0:15];
    logic raw_bits [0:511];
    logic exp_bits [0:511];
    logic cap_bits [0:511];
    int raw_n, exp_n;
    int cap_n = 0;
    int first_cyc = 0;
    bit cap_on = 1'b0;

    always @(negedge clk) begin
        if (cap_on && ser_en) begin
            if (cap_n == 0) first_cyc = cyc;
            if (cap_n < 512) cap_bits[cap_n] = ser_bit;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic add_raw(input logic b);
        raw_bits[raw_n] = b;
        raw_n++;
    endtask

    // model: SYNC, LSB-first data with stuffing, trailing stuff, EOP, NRZI
    task automatic build(input int n, input bit raw);
        int   run;
        logic line;
        raw_n = 0;
        for (int i = 0; i < 31; i++) add_raw(1'b0);
        add_raw(1'b1);
        run = 1;
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < 8; j++) begin
                add_raw(pkt[k][j]);
                if (!raw) begin
                    run = pkt[k][j] ? run + 1 : 0;
                    if (run == 6) begin
                        add_raw(1'b0);
                        run = 0;
                    end
                end
            end
        end
        for (int i = 0; i < 8; i++) add_raw(1'b1);
        line = 1'b1;
        for (int i = 0; i < raw_n; i++) begin
            if (raw) exp_bits[i] = raw_bits[i];
            else begin
                if (!raw_bits[i]) line = ~line;
                exp_bits[i] = line;
            end
        end
        exp_n = raw_n;
    endtask

    task automatic send_packet(input int n, input logic [1:0] mode, input string req);
        int idx, idle, bad_rdy, late_rdy, mism, first_bad, start_cyc;
        bit acc;
        op_mode = mode;
        build(n, mode == 2'b10);
        @(negedge clk);
        cap_n = 0;
        cap_on = 1'b1;
        tx_valid = 1'b1;
        tx_data = pkt[0];
        start_cyc = cyc + 1;
        idx = 0;
        bad_rdy = 0;
        late_rdy = 0;
        while (tx_valid) begin
            acc = tx_ready;
            @(negedge clk);
            if (acc) begin
                if (tx_ready) bad_rdy++;
                idx++;
                if (idx < n) tx_data = pkt[idx];
                else begin
                    tx_valid = 1'b0;
                    tx_data = 8'($urandom);
                end
            end
        end
        idle = 0;
        while (idle < 16 || cap_n == 0) begin
            @(negedge clk);
            if (tx_ready) late_rdy++;
            if (ser_en) idle = 0;
            else idle++;
        end
        cap_on = 1'b0;
        mism = 0;
        first_bad = -1;
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            if (cap_bits[i] !== exp_bits[i]) begin
                if (first_bad < 0) first_bad = i;
                mism++;
            end
        end
        chk(bad_rdy == 0, "R2 ready low after take", bad_rdy, 0);
        chk(late_rdy == 0, "R7 ready after valid fell", late_rdy, 0);
        chk(first_cyc - start_cyc >= 8 && first_cyc - start_cyc <= 16,
            "R3 start latency", first_cyc - start_cyc, 9);
        chk(cap_n == exp_n, {req, " bit count"}, cap_n, exp_n);
        chk(mism == 0, {req, " first bit mismatch index"}, first_bad, -1);
        chk(cap_n >= 8 && cap_bits[cap_n-1] == cap_bits[cap_n-8],
            "R6 EOP holds line", cap_n, exp_n);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, ens, rdys;
        void'($urandom(32'h1d5e));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_ready == 1'b0, "R1 tx_ready", tx_ready, 0);
        chk(ser_en == 1'b0, "R1 ser_en", ser_en, 0);
        chk(ser_bit == 1'b1, "R1 ser_bit", ser_bit, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 long runs of ones
        for (int i = 0; i < 4; i++) pkt[i] = 8'hFF;
        send_packet(4, 2'b00, "R4 ones runs");
        // R4 trailing stuff after last bit
        pkt[0] = 8'hFC;
        send_packet(1, 2'b00, "R4 trailing stuff");
        // R5 all zeros toggle every bit
        for (int i = 0; i < 3; i++) pkt[i] = 8'h00;
        send_packet(3, 2'b00, "R5 zeros");
        // R8 raw mode, no stuffing on 0xFF
        for (int i = 0; i < 3; i++) pkt[i] = 8'hFF;
        send_packet(3, 2'b10, "R8 raw");
        // R2 random packets, mode 3 behaves as normal
        for (int p = 0; p < 6; p++) begin
            n = 1 + int'($urandom % 12);
            for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
            send_packet(n, (p == 5) ? 2'b11 : 2'b00, "R2 random");
        end

        // R9 silent mode ignores valid
        op_mode = 2'b01;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data = 8'hA5;
        ens = 0;
        rdys = 0;
        repeat (60) begin
            @(negedge clk);
            if (ser_en) ens++;
            if (tx_ready) rdys++;
        end
        chk(ens == 0, "R9 ser_en in silent mode", ens, 0);
        chk(rdys == 0, "R9 tx_ready in silent mode", rdys, 0);
        tx_valid = 1'b0;
        op_mode = 2'b00;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule